// File: doc/BRIEF.md
# Auto-Triggered Conversion Sequencer

This block is the digital controller that sits beside a successive-approximation converter. It divides the system clock into a converter clock-enable, `conv_tick`. The divide ratio is selectable and is a power of two from 2 to 128. A counter is held at zero whenever the block is disabled. A conversion is requested by a one-cycle software start strobe, or by a rising edge on a hardware trigger line chosen by a select field. The hardware path works only while auto-triggering is on. Software starts keep working when auto-triggering is on.

Select code 0 chooses the block's own end-of-conversion event as the trigger, so the converter runs continuously. Software has to launch the first conversion in that mode. The flag state has no effect on the restarts. When the amplified-channel indicator is high, this free-running restart is suppressed. The comparator decisions arrive one bit per converter tick on `cmp_bit`. The last samples of a conversion are loaded into the result register at completion. At the same edge the completion flag is set and a one-cycle end strobe is issued.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `div_sel` value k selects a converter tick every 2^k enabled clocks, and value 0 behaves as value 1 (every 2). A conversion accepted at tick edge t completes at edge t + L*ratio, where L is the conversion length in ticks.
- R2: While `en` is low the divider is held at zero and `conv_tick` stays low. After `en` rises, the first tick edge is the ratio-th enabled clock edge, and every later tick edge falls on a multiple of the ratio.
- R3: The first conversion after `en` rises takes 25 converter ticks, and every later conversion takes 13.
- R4: A `start_wr` pulse while idle is accepted at the first tick edge strictly after the edge that sampled it. This holds whether `auto_en` is high or low.
- R5: `busy` is 1 from the edge that registers a start request (software or hardware) through the completion edge, and it is 0 right after a completion that does not restart.
- R6: With `auto_en` high, a `trig_sel` code n in 1..7 makes a rising edge on `trig_src[n-1]` a start request. Edges on other lines, or any edge while `auto_en` is low, are ignored.
- R7: Start requests of either kind that arrive while `busy` is 1 are dropped and are not queued.
- R8: With `auto_en` high, `trig_sel` = 0 and `amp_ch` low, each completion immediately starts the next conversion at the same edge, whether or not `done_flag` was cleared. No hardware start occurs from idle in this mode.
- R9: When `amp_ch` is high, a completion never restarts a conversion, so `busy` returns to 0.
- R10: At completion, `result` holds the last 10 `cmp_bit` values sampled on the conversion's tick edges, with the earliest sample in the MSB. `done_flag` is set and `eoc` pulses for one cycle.
- R11: `done_flag` stays set until a `flag_clr` pulse clears it. A completion in the same cycle wins over the clear.
- R12: While `en` is low, start requests are ignored and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low holds the divider and sequencer idle |
| start_wr | input | 1 | One-cycle software start strobe |
| auto_en | input | 1 | Enables hardware trigger starts |
| trig_sel | input | 3 | Trigger choice: 0 = own completion, n = trig_src[n-1] |
| trig_src | input | 7 | Hardware trigger lines |
| div_sel | input | 3 | Divide-ratio select (0,1 = 2; k = 2^k) |
| amp_ch | input | 1 | Amplified channel selected; blocks free-running |
| cmp_bit | input | 1 | Serial comparator decision, sampled on ticks |
| flag_clr | input | 1 | Clears the completion flag |
| conv_tick | output | 1 | Converter clock-enable |
| busy | output | 1 | Conversion pending or in progress |
| eoc | output | 1 | One-cycle end-of-conversion strobe |
| done_flag | output | 1 | Sticky completion flag |
| result | output | 10 | Last conversion result |

## Verification
A wrong tick count or a divider out of phase moves the `eoc` strobe off the expected edge. That error shows at the first completion, which is at most 25 ticks after a start. A sequencer that queues or mis-gates a request shows up as an unexpected `eoc`, or as `busy` staying high, within one conversion length. Shift errors appear in `result` at the same completion edge. A flag or restart fault is visible one cycle after `eoc`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_CONV = 2'd2
   } seq_state_t;
endpackage

// File: rtl/adc_prescale.sv
module adc_prescale #(
   parameter int PRE_W = 7,
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div_sel,
   output logic             tick
);
   logic [PRE_W-1:0] cnt;
   logic [PRE_W-1:0] mask;

   // bit i of the mask is set below the selected exponent; bit 0 always set
   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = (i == 0) || (32'(i) < 32'(div_sel));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (!en) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   assign tick = en && ((cnt & mask) == mask);
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
   parameter int NSRC  = 7,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  trig_src,
   input  logic [SEL_W-1:0] trig_sel,
   input  logic             auto_en,
   input  logic             amp_ch,
   output logic             hw_start,
   output logic             fr_en
);
   logic line;
   logic line_q;

   always_comb begin
      line = 1'b0;
      for (int i = 0; i < NSRC; i++) begin
         if (trig_sel == SEL_W'(i + 1)) line = trig_src[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line;
   end

   assign hw_start = auto_en && line && !line_q;
   assign fr_en    = auto_en && (trig_sel == '0) && !amp_ch;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_seq_pkg::*;
#(
   parameter int RES_W     = 10,
   parameter int LEN_NORM  = 13,
   parameter int LEN_FIRST = 25,
   parameter int CNT_W     = $clog2(LEN_FIRST)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             sw_start,
   input  logic             hw_start,
   input  logic             fr_en,
   input  logic             cmp_bit,
   input  logic             flag_clr,
   output logic             busy,
   output logic             eoc,
   output logic             done_flag,
   output logic [RES_W-1:0] result
);
   seq_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] len_m1;
   logic             first;
   logic [RES_W-2:0] sh;
   logic [RES_W-1:0] sh_next;
   logic             finish;

   assign len_m1  = first ? CNT_W'(LEN_FIRST - 1) : CNT_W'(LEN_NORM - 1);
   assign sh_next = {sh, cmp_bit};
   assign finish  = en && (st == SEQ_CONV) && tick && (cnt == len_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SEQ_IDLE;
         cnt       <= '0;
         first     <= 1'b1;
         sh        <= '0;
         result    <= '0;
         done_flag <= 1'b0;
         eoc       <= 1'b0;
      end else begin
         eoc <= finish;
         if (finish)        done_flag <= 1'b1;
         else if (flag_clr) done_flag <= 1'b0;
         if (!en) begin
            st    <= SEQ_IDLE;
            cnt   <= '0;
            first <= 1'b1;
         end else begin
            case (st)
               SEQ_IDLE: if (sw_start || hw_start) st <= SEQ_WAIT;
               SEQ_WAIT: if (tick) begin
                  st  <= SEQ_CONV;
                  cnt <= '0;
               end
               SEQ_CONV: if (tick) begin
                  sh <= sh_next[RES_W-2:0];
                  if (cnt == len_m1) begin
                     result <= sh_next;
                     first  <= 1'b0;
                     cnt    <= '0;
                     if (!fr_en) st <= SEQ_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= SEQ_IDLE;
            endcase
         end
      end
   end

   assign busy = (st != SEQ_IDLE);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int NSRC      = 7,
   parameter int SEL_W     = 3,
   parameter int PRE_W     = 7,
   parameter int RES_W     = 10,
   parameter int LEN_NORM  = 13,
   parameter int LEN_FIRST = 25,
   localparam int DIV_W    = $clog2(PRE_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start_wr,
   input  logic             auto_en,
   input  logic [SEL_W-1:0] trig_sel,
   input  logic [NSRC-1:0]  trig_src,
   input  logic [DIV_W-1:0] div_sel,
   input  logic             amp_ch,
   input  logic             cmp_bit,
   input  logic             flag_clr,
   output logic             conv_tick,
   output logic             busy,
   output logic             eoc,
   output logic             done_flag,
   output logic [RES_W-1:0] result
);
   if (NSRC < 1 || NSRC > (1 << SEL_W) - 1) begin : g_bad_nsrc
      $error("trigger source count does not fit the select field");
   end
   if (RES_W < 2 || RES_W > LEN_NORM) begin : g_bad_res
      $error("result width must be 2..LEN_NORM");
   end
   if (LEN_FIRST < LEN_NORM) begin : g_bad_len
      $error("first conversion may not be shorter than a normal one");
   end

   logic hw_start;
   logic fr_en;

   adc_prescale #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .div_sel (div_sel),
      .tick    (conv_tick)
   );

   adc_trig_edge #(.NSRC(NSRC), .SEL_W(SEL_W)) u_trg (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_src (trig_src),
      .trig_sel (trig_sel),
      .auto_en  (auto_en),
      .amp_ch   (amp_ch),
      .hw_start (hw_start),
      .fr_en    (fr_en)
   );

   adc_conv_seq #(.RES_W(RES_W), .LEN_NORM(LEN_NORM), .LEN_FIRST(LEN_FIRST)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .tick      (conv_tick),
      .sw_start  (start_wr),
      .hw_start  (hw_start),
      .fr_en     (fr_en),
      .cmp_bit   (cmp_bit),
      .flag_clr  (flag_clr),
      .busy      (busy),
      .eoc       (eoc),
      .done_flag (done_flag),
      .result    (result)
   );
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int SEL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             auto_en,
   input logic [SEL_W-1:0] trig_sel,
   input logic             amp_ch,
   input logic             flag_clr,
   input logic             conv_tick,
   input logic             busy,
   input logic             eoc,
   input logic             done_flag
);
   assert_tick_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> $past(conv_tick));
   assert_no_tick_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !conv_tick);
   assert_busy_before_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> $past(busy));
   assert_free_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && $past(en && auto_en && (trig_sel == '0) && !amp_ch)) |-> busy);
   assert_amp_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && $past(amp_ch)) |-> !busy);
   assert_flag_on_eoc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> done_flag);
   assert_eoc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);
   assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !flag_clr) |=> done_flag);
   assert_idle_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .auto_en   (auto_en),
   .trig_sel  (trig_sel),
   .amp_ch    (amp_ch),
   .flag_clr  (flag_clr),
   .conv_tick (conv_tick),
   .busy      (busy),
   .eoc       (eoc),
   .done_flag (done_flag)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   localparam int NSRC  = 7;
   localparam int RES_W = 10;

   logic             clk = 1'b0;
   logic             rst_n, en, start_wr, auto_en, amp_ch, cmp_bit, flag_clr;
   logic [2:0]       trig_sel, div_sel;
   logic [NSRC-1:0]  trig_src;
   logic             conv_tick, busy, eoc, done_flag;
   logic [RES_W-1:0] result;

   always #10 clk = ~clk;

   adc_seq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .en(en), .start_wr(start_wr), .auto_en(auto_en),
      .trig_sel(trig_sel), .trig_src(trig_src), .div_sel(div_sel), .amp_ch(amp_ch),
      .cmp_bit(cmp_bit), .flag_clr(flag_clr), .conv_tick(conv_tick), .busy(busy),
      .eoc(eoc), .done_flag(done_flag), .result(result)
   );

   int checks = 0;
   int bad    = 0;
   int en_edges = 0;
   int exp_f[$];
   logic [RES_W-1:0] exp_r[$];
   int f_now;
   logic [RES_W-1:0] r_now;

   always @(posedge clk) begin
      if (!en) en_edges <= 0;
      else     en_edges <= en_edges + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // monitor: pops the expected completion edge and result on every strobe
   always @(negedge clk) begin
      if (rst_n && eoc) begin
         if (exp_f.size() == 0) begin
            check(1'b0, "R7", "unexpected completion at edge", en_edges, -1);
         end else begin
            f_now = exp_f.pop_front();
            r_now = exp_r.pop_front();
            check(en_edges == f_now, "R1/R3", "completion edge", en_edges, f_now);
            check(result == r_now, "R10", "result", int'(result), int'(r_now));
            check(done_flag == 1'b1, "R10", "flag at completion", int'(done_flag), 1);
         end
      end
   end

   // driver: issues a start and pushes the predicted completion
   task automatic launch(input bit use_trig, input int idx, input int ratio,
                         input int len, input logic [RES_W-1:0] rexp, output int f);
      int s, t;
      @(negedge clk);
      s = en_edges + 1;
      if (use_trig) trig_src[idx] = 1'b1;
      else          start_wr = 1'b1;
      t = (s / ratio + 1) * ratio;
      f = t + len * ratio;
      exp_f.push_back(f);
      exp_r.push_back(rexp);
      @(negedge clk);
      start_wr = 1'b0;
      trig_src = '0;
      check(busy == 1'b1, "R5", "busy after start", int'(busy), 1);
   endtask

   task automatic drain();
      int n = 0;
      while (exp_f.size() != 0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wait_edge(input int e);
      while (en_edges < e) @(negedge clk);
   endtask

   task automatic clear_flag();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      check(done_flag == 1'b0, "R11", "flag after clear", int'(done_flag), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      int f;
      rst_n = 0; en = 0; start_wr = 0; auto_en = 0; amp_ch = 0; cmp_bit = 0;
      flag_clr = 0; trig_sel = 0; div_sel = 0; trig_src = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(busy == 0, "R5", "reset busy", int'(busy), 0);
      check(done_flag == 0, "R11", "reset flag", int'(done_flag), 0);
      check(result == 0, "R10", "reset result", int'(result), 0);
      check(conv_tick == 0, "R2", "tick while disabled", int'(conv_tick), 0);

      // R12: start while disabled
      start_wr = 1;
      @(negedge clk);
      start_wr = 0;
      repeat (3) @(negedge clk);
      check(busy == 0, "R12", "busy after start while disabled", int'(busy), 0);

      // R2: tick phase from enable, ratio 8
      div_sel = 3;
      en = 1;
      wait_edge(6);
      check(conv_tick == 0, "R2", "tick before 8th edge", int'(conv_tick), 0);
      wait_edge(7);
      check(conv_tick == 1, "R2", "tick at 8th edge", int'(conv_tick), 1);

      // R3/R4: first conversion, 25 ticks
      cmp_bit = 1;
      launch(0, 0, 8, 25, 10'h3FF, f);
      drain();
      check(busy == 0, "R5", "busy after completion", int'(busy), 0);
      repeat (5) @(negedge clk);
      check(done_flag == 1, "R11", "flag held", int'(done_flag), 1);
      clear_flag();

      // R3: normal length, zeros
      cmp_bit = 0;
      launch(0, 0, 8, 13, 10'h000, f);
      drain();
      clear_flag();

      // R10: sample order, last three samples zero
      cmp_bit = 1;
      launch(0, 0, 8, 13, 10'h3F8, f);
      wait_edge(f - 24);
      cmp_bit = 0;
      drain();
      clear_flag();

      // R6: hardware trigger on line 1 (code 2); R7: repeats while busy ignored
      cmp_bit = 1;
      auto_en = 1;
      trig_sel = 2;
      launch(1, 1, 8, 13, 10'h3FF, f);
      repeat (40) @(negedge clk);
      trig_src[1] = 1;
      start_wr = 1;
      @(negedge clk);
      trig_src = '0;
      start_wr = 0;
      drain();
      repeat (140) @(negedge clk);
      check(busy == 0, "R7", "no queued start", int'(busy), 0);
      check(exp_f.size() == 0, "R7", "pending expectations", exp_f.size(), 0);
      clear_flag();

      // R6: wrong line, then auto disabled
      trig_src[0] = 1;
      @(negedge clk);
      trig_src = '0;
      repeat (20) @(negedge clk);
      check(busy == 0, "R6", "wrong line ignored", int'(busy), 0);
      auto_en = 0;
      trig_src[1] = 1;
      @(negedge clk);
      trig_src = '0;
      repeat (20) @(negedge clk);
      check(busy == 0, "R6", "trigger with auto off ignored", int'(busy), 0);

      // R4: software start with auto on
      auto_en = 1;
      launch(0, 0, 8, 13, 10'h3FF, f);
      drain();
      clear_flag();
      auto_en = 0;

      // R1: ratio 128 and ratio 2 (code 0)
      div_sel = 7;
      launch(0, 0, 128, 13, 10'h3FF, f);
      drain();
      clear_flag();
      div_sel = 0;
      cmp_bit = 0;
      launch(0, 0, 2, 13, 10'h000, f);
      drain();
      clear_flag();

      // R8: free running, flag left set
      cmp_bit = 1;
      div_sel = 2;
      trig_sel = 0;
      auto_en = 1;
      launch(0, 0, 4, 13, 10'h3FF, f);
      exp_f.push_back(f + 52);  exp_r.push_back(10'h3FF);
      exp_f.push_back(f + 104); exp_r.push_back(10'h3FF);
      wait_edge(f + 60);
      check(busy == 1, "R8", "busy in free run", int'(busy), 1);
      auto_en = 0;
      drain();
      repeat (100) @(negedge clk);
      check(busy == 0, "R8", "stopped after auto off", int'(busy), 0);
      check(done_flag == 1, "R8", "flag never cleared", int'(done_flag), 1);
      clear_flag();

      // R9: amplified channel blocks free running
      auto_en = 1;
      amp_ch = 1;
      launch(0, 0, 4, 13, 10'h3FF, f);
      drain();
      repeat (5) @(negedge clk);
      check(busy == 0, "R9", "no restart on amplified channel", int'(busy), 0);
      repeat (100) @(negedge clk);
      clear_flag();
      amp_ch = 0;
      auto_en = 0;

      // R2/R3: re-enable resets divider and first-conversion length
      en = 0;
      repeat (5) @(negedge clk);
      check(conv_tick == 0, "R2", "tick held off", int'(conv_tick), 0);
      div_sel = 1;
      en = 1;
      launch(0, 0, 2, 25, 10'h3FF, f);
      drain();
      clear_flag();

      repeat (10) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule